// File: doc/BRIEF.md
# Quad Word Read Command Sequencer

This block is the target-side control for a four-line word read on a serial flash port. A transaction opens when chip select falls. The block takes an 8-bit command on line 0, then a 24-bit start address and an 8-bit mode byte over all four lines. Two dummy clocks follow. After that, the block streams bytes from the memory array as nibbles, and the read address steps up by one for each byte. The mode byte can arm a continuous mode. In that mode, the following transactions start directly with the address and carry no command.

The block runs on a fast system clock. The serial clock reaches it as a one-cycle strobe, `sck_tick`, which marks each serial rising edge and has already been synchronized upstream. The host drives `io_in` before the strobe, and the block samples it on the strobe. Output nibbles change on the strobe, and the host samples them on its next strobe. The array is read through a combinational request port: `fetch_data` must be valid in the same cycle as `fetch_req`.

Top module: `qwr_word_read`

## Requirements
- R1: After reset the output enable and fetch request are low, `io_out` is 0 and continuous mode is off, so the first transaction must begin with a command byte.
- R2: The command byte is sampled on `io_in[0]`, most significant bit first, over 8 ticks. Only 8'hE7 proceeds. Any other code abandons the transaction: no fetch and no output enable until chip select rises.
- R3: After the command, 8 ticks carry the address and then the mode byte as nibbles on `io_in[3:0]`, high nibble first. Address bits 23..0 come first, then mode bits 7..0.
- R4: Two dummy ticks follow the mode byte. On the second one, `fetch_req` is high for one cycle with `fetch_addr` equal to the start address, and `io_oe` rises in the next cycle.
- R5: Each byte goes out high nibble first on `io_out` and changes only on a tick. After the fetch tick `io_out` holds bits 7..4. After the next tick it holds bits 3..0.
- R6: Each byte after the first is fetched on the tick that completes the previous byte. The fetch address is the previous one plus one, modulo 2^24.
- R7: A start address with bit 0 set abandons the transaction.
- R8: If `qe_en` is low on the last mode tick, the transaction is abandoned.
- R9: If mode bits 7..4 equal 4'hA, the next transaction starts at the address phase with no command. Any other mode value requires the command again.
- R10: In continuous mode, 8 quad ticks with all lines high act as the mode reset sequence: the transaction is abandoned and command decoding resumes.
- R11: Raising chip select at any point drops `io_oe` in the same cycle and returns the sequencer to idle. The continuous mode flag keeps its last captured value.
- R12: `io_oe` is low throughout the command, address, mode and dummy phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck_tick | input | 1 | One-cycle strobe per serial clock rising edge |
| io_in | input | 4 | Data lines from host |
| qe_en | input | 1 | Quad-enable status bit |
| io_out | output | 4 | Data nibble toward host |
| io_oe | output | 1 | Output enable for io_out |
| fetch_req | output | 1 | Byte fetch strobe to the array |
| fetch_addr | output | 24 | Address of the byte being fetched |
| fetch_data | input | 8 | Byte returned by the array, same cycle |

## Verification
A tick counter off by one in any phase moves the cycle in which `fetch_req` pulses or `io_oe` rises. That shows at the ports within the same transaction, one tick early or late. A corrupted address shift register or address counter shows on `fetch_addr` at the first fetch, and as a wrong nibble on `io_out` one tick later. A wrong continuous mode flag only shows in the following transaction: that read either proceeds when it should be abandoned or stays silent when it should proceed.

// File: rtl/qwr_pkg.sv
`timescale 1ns/1ps
package qwr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_HALT
  } qwr_phase_e;
endpackage

// File: rtl/qwr_in_shift.sv
`timescale 1ns/1ps
module qwr_in_shift #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_cmd,
  input  logic              shift_quad,
  input  logic [3:0]        io_in,
  output logic [7:0]        cmd_next,
  output logic [ADDR_W-1:0] start_addr,
  output logic [3:0]        mode_hi,
  output logic              addr_lsb
);
  localparam int QW = ADDR_W + 8;

  logic [6:0]    cmd_q;
  logic [QW-5:0] quad_q;
  logic [QW-1:0] quad_next;

  assign cmd_next   = {cmd_q, io_in[0]};
  assign quad_next  = {quad_q, io_in};
  assign start_addr = quad_next[QW-1:8];
  assign mode_hi    = quad_next[7:4];
  assign addr_lsb   = quad_next[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      quad_q <= '0;
    end else begin
      if (shift_cmd)  cmd_q  <= cmd_next[6:0];
      if (shift_quad) quad_q <= quad_next[QW-5:0];
    end
  end
endmodule

// File: rtl/qwr_fsm.sv
`timescale 1ns/1ps
module qwr_fsm
  import qwr_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         DUMMY_CLKS = 2,
  parameter logic [7:0] CMD_CODE   = 8'hE7,
  parameter logic [3:0] CONT_KEY   = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       tick,
  input  logic       qe_en,
  input  logic [7:0] cmd_next,
  input  logic [3:0] mode_hi,
  input  logic       addr_lsb,
  output qwr_phase_e phase,
  output logic       shift_cmd,
  output logic       shift_quad,
  output logic       load_addr,
  output logic       fetch_now,
  output logic       show_lo
);
  localparam int ADDR_TICKS = ADDR_W / 4 + 2;
  localparam int CNT_W      = $clog2(ADDR_TICKS + DUMMY_CLKS + 8);

  qwr_phase_e phase_q, phase_d, eff_ph;
  logic [CNT_W-1:0] cnt_q, cnt_d, eff_cnt;
  logic cont_q, cont_d;
  logic lo_q, lo_d;

  assign phase   = phase_q;
  assign eff_ph  = (phase_q == PH_IDLE) ? (cont_q ? PH_ADDR : PH_CMD) : phase_q;
  assign eff_cnt = (phase_q == PH_IDLE) ? '0 : cnt_q;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    cont_d     = cont_q;
    lo_d       = lo_q;
    shift_cmd  = 1'b0;
    shift_quad = 1'b0;
    load_addr  = 1'b0;
    fetch_now  = 1'b0;
    show_lo    = 1'b0;
    if (cs_n) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      phase_d = eff_ph;
      cnt_d   = eff_cnt;
      if (tick) begin
        case (eff_ph)
          PH_CMD: begin
            shift_cmd = 1'b1;
            if (eff_cnt == CNT_W'(7)) begin
              cnt_d   = '0;
              phase_d = (cmd_next == CMD_CODE) ? PH_ADDR : PH_HALT;
            end else begin
              cnt_d = eff_cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            shift_quad = 1'b1;
            if (eff_cnt == CNT_W'(ADDR_TICKS - 1)) begin
              cnt_d  = '0;
              cont_d = (mode_hi == CONT_KEY);
              if (addr_lsb || !qe_en) begin
                phase_d = PH_HALT;
              end else begin
                load_addr = 1'b1;
                phase_d   = PH_DUMMY;
              end
            end else begin
              cnt_d = eff_cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (eff_cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              fetch_now = 1'b1;
              lo_d      = 1'b0;
              phase_d   = PH_DATA;
            end else begin
              cnt_d = eff_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (lo_q) begin
              fetch_now = 1'b1;
              lo_d      = 1'b0;
            end else begin
              show_lo = 1'b1;
              lo_d    = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cont_q  <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cont_q  <= cont_d;
      lo_q    <= lo_d;
    end
  end
endmodule

// File: rtl/qwr_out_stage.sv
`timescale 1ns/1ps
module qwr_out_stage #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              fetch_now,
  input  logic              show_lo,
  input  logic [7:0]        fetch_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [3:0]        io_out
);
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        low_q;
  logic [3:0]        out_q;

  assign fetch_addr = addr_q;
  assign io_out     = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      low_q  <= '0;
      out_q  <= '0;
    end else begin
      if (load_addr)      addr_q <= start_addr;
      else if (fetch_now) addr_q <= addr_q + 1'b1;
      if (fetch_now) begin
        low_q <= fetch_data[3:0];
        out_q <= fetch_data[7:4];
      end else if (show_lo) begin
        out_q <= low_q;
      end
    end
  end
endmodule

// File: rtl/qwr_word_read.sv
`timescale 1ns/1ps
module qwr_word_read
  import qwr_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         DUMMY_CLKS = 2,
  parameter logic [7:0] CMD_CODE   = 8'hE7,
  parameter logic [3:0] CONT_KEY   = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_tick,
  input  logic [3:0]        io_in,
  input  logic              qe_en,
  output logic [3:0]        io_out,
  output logic              io_oe,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [7:0]        fetch_data
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              shift_cmd, shift_quad, load_addr, fetch_now, show_lo;
  logic [7:0]        cmd_next;
  logic [ADDR_W-1:0] start_addr;
  logic [3:0]        mode_hi;
  logic              addr_lsb;
  qwr_phase_e        phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  qwr_in_shift #(.ADDR_W(ADDR_W)) in_i (
    .clk(clk), .rst_n(rst_int_n), .shift_cmd(shift_cmd), .shift_quad(shift_quad),
    .io_in(io_in), .cmd_next(cmd_next), .start_addr(start_addr),
    .mode_hi(mode_hi), .addr_lsb(addr_lsb)
  );

  qwr_fsm #(.ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS), .CMD_CODE(CMD_CODE),
            .CONT_KEY(CONT_KEY)) fsm_i (
    .clk(clk), .rst_n(rst_int_n), .cs_n(cs_n), .tick(sck_tick), .qe_en(qe_en),
    .cmd_next(cmd_next), .mode_hi(mode_hi), .addr_lsb(addr_lsb), .phase(phase),
    .shift_cmd(shift_cmd), .shift_quad(shift_quad), .load_addr(load_addr),
    .fetch_now(fetch_now), .show_lo(show_lo)
  );

  qwr_out_stage #(.ADDR_W(ADDR_W)) out_i (
    .clk(clk), .rst_n(rst_int_n), .load_addr(load_addr), .start_addr(start_addr),
    .fetch_now(fetch_now), .show_lo(show_lo), .fetch_data(fetch_data),
    .fetch_addr(fetch_addr), .io_out(io_out)
  );

  assign io_oe     = (phase == PH_DATA) && !cs_n;
  assign fetch_req = fetch_now;
endmodule

// File: rtl/qwr_seq_chk.sv
`timescale 1ns/1ps
module qwr_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sck_tick,
  input logic              io_oe,
  input logic [3:0]        io_out,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr
);
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_addr <= '0;
    else if (fetch_req) last_addr <= fetch_addr;
  end

  AST_OE_DROPS_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !io_oe); // R11
  AST_FETCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (sck_tick && !cs_n)); // R4
  AST_FIRST_FETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !io_oe) |-> !fetch_addr[0]); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && io_oe) |-> (fetch_addr == ADDR_W'(last_addr + 1'b1))); // R6
  AST_OE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe) |-> $past(fetch_req)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sck_tick) |-> $stable(io_out)); // R5
endmodule

bind qwr_word_read qwr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_tick(sck_tick), .io_oe(io_oe),
  .io_out(io_out), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
);

// File: tb/qwr_word_read_tb_top.sv
`timescale 1ns/1ps
module qwr_word_read_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck_tick = 1'b0;
  logic [3:0]  io_in = 4'h0;
  logic        qe_en = 1'b1;
  logic [3:0]  io_out;
  logic        io_oe;
  logic        fetch_req;
  logic [23:0] fetch_addr;
  logic [7:0]  fetch_data;

  int vectors = 0;
  int fails   = 0;
  logic        fr;
  logic [23:0] fa;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
  endfunction

  assign fetch_data = memf(fetch_addr);

  qwr_word_read dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_tick(sck_tick), .io_in(io_in),
    .qe_en(qe_en), .io_out(io_out), .io_oe(io_oe), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] nib);
    @(negedge clk);
    io_in = nib;
    sck_tick = 1'b1;
    #1;
    fr = fetch_req;
    fa = fetch_addr;
    @(negedge clk);
    sck_tick = 1'b0;
  endtask

  task automatic close_cs();
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check(io_oe == 1'b0, "R11 oe on cs rise", {31'd0, io_oe}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_txn(input bit send_cmd, input logic [7:0] cmd,
                         input logic [23:0] a, input logic [7:0] m,
                         input bit ok, input int nbytes, input string tag,
                         input int cut);
    logic [31:0] word;
    logic [23:0] cur;
    word = {a, m};
    @(negedge clk);
    cs_n = 1'b0;
    if (send_cmd) begin
      for (int i = 0; i < 8; i++) begin
        tick({3'b000, cmd[7-i]});
        check(!io_oe && !fr, "R12 oe in command", {31'd0, io_oe}, 32'd0);
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (cut != 0 && i == cut) begin
        close_cs();
        return;
      end
      tick(word[31-4*i -: 4]);
      check(!io_oe && !fr, "R12 oe in address", {31'd0, io_oe}, 32'd0);
    end
    tick(4'h0);
    check(!io_oe && !fr, "R12 R4 first dummy", {30'd0, io_oe, fr}, 32'd0);
    tick(4'h0);
    if (ok) begin
      check(fr && fa == a, {tag, " R4 first fetch"}, {7'd0, fr, fa}, {8'd1, a});
      check(io_oe && io_out == memf(a)[7:4], {tag, " R5 first high nibble"},
            {27'd0, io_oe, io_out}, {27'd1, memf(a)[7:4]});
      cur = a;
      for (int k = 0; k < nbytes; k++) begin
        tick(4'h5);
        check(!fr && io_out == memf(cur)[3:0], {tag, " R5 low nibble"},
              {27'd0, fr, io_out}, {28'd0, memf(cur)[3:0]});
        tick(4'hA);
        cur = cur + 24'd1;
        check(fr && fa == cur, {tag, " R6 next fetch"}, {7'd0, fr, fa}, {8'd1, cur});
        check(io_oe && io_out == memf(cur)[7:4], {tag, " R5 R6 next high nibble"},
              {27'd0, io_oe, io_out}, {27'd1, memf(cur)[7:4]});
      end
    end else begin
      check(!fr && !io_oe, {tag, " abandoned at dummy end"}, {30'd0, fr, io_oe}, 32'd0);
      for (int k = 0; k < 4; k++) begin
        tick(4'hF);
        check(!fr && !io_oe, {tag, " stays silent"}, {30'd0, fr, io_oe}, 32'd0);
      end
    end
    close_cs();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!io_oe && !fetch_req && io_out == 4'h0, "R1 reset outputs",
          {26'd0, io_oe, fetch_req, io_out}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!io_oe && !fetch_req && io_out == 4'h0, "R1 after release",
          {26'd0, io_oe, fetch_req, io_out}, 32'd0);
    // R1: continuous mode off, a read without command is decoded as command 0x08
    run_txn(1'b0, 8'h00, 24'h000010, 8'h00, 1'b0, 0, "R1", 0);

    // R3 R5 R6: sweep of even start addresses and lengths
    for (int i = 0; i < 24; i++) begin
      logic [23:0] a;
      a = (24'h13579A ^ (24'(i) << 13) ^ (24'(i) * 24'h0A3)) & 24'hFFFFFE;
      run_txn(1'b1, 8'hE7, a, 8'(i * 16'h11) & 8'h5F, 1'b1, 1 + i % 4, "R3", 0);
    end

    // R2: wrong command codes
    begin
      logic [7:0] bad [5] = '{8'hE6, 8'h67, 8'hF7, 8'h00, 8'hE5};
      for (int i = 0; i < 5; i++)
        run_txn(1'b1, bad[i], 24'h000100, 8'h00, 1'b0, 0, "R2", 0);
    end
    run_txn(1'b1, 8'hE7, 24'h000100, 8'h00, 1'b1, 2, "R2 recovery", 0);

    // R7: odd start address
    run_txn(1'b1, 8'hE7, 24'h000101, 8'h00, 1'b0, 0, "R7", 0);
    run_txn(1'b1, 8'hE7, 24'hABCDEF, 8'h00, 1'b0, 0, "R7", 0);

    // R8: quad enable clear
    qe_en = 1'b0;
    run_txn(1'b1, 8'hE7, 24'h000200, 8'h00, 1'b0, 0, "R8", 0);
    qe_en = 1'b1;

    // R6: address wraps modulo 2^24
    run_txn(1'b1, 8'hE7, 24'hFFFFFE, 8'h00, 1'b1, 3, "R6 wrap", 0);

    // R9: continuous mode armed by mode 0xA5, kept by 0xA0
    run_txn(1'b1, 8'hE7, 24'h002468, 8'hA5, 1'b1, 1, "R9 arm", 0);
    run_txn(1'b0, 8'h00, 24'h00ACE0, 8'hA0, 1'b1, 2, "R9 no command", 0);
    run_txn(1'b0, 8'h00, 24'h123456, 8'hB0, 1'b1, 1, "R9 no command", 0);
    // mode 0xB0 disarmed: a read without command is decoded as command 0x00
    run_txn(1'b0, 8'h00, 24'h000200, 8'h00, 1'b0, 0, "R9 disarmed", 0);
    run_txn(1'b1, 8'hE7, 24'h000200, 8'h00, 1'b1, 1, "R9 command again", 0);

    // R11: chip select raised mid-address keeps continuous mode
    run_txn(1'b1, 8'hE7, 24'h000400, 8'hAF, 1'b1, 1, "R11 arm", 0);
    run_txn(1'b0, 8'h00, 24'h777777, 8'h00, 1'b1, 0, "R11 cut", 3);
    run_txn(1'b0, 8'h00, 24'h000402, 8'hA1, 1'b1, 2, "R11 kept", 0);

    // R10: all-ones sequence clears continuous mode
    run_txn(1'b0, 8'h00, 24'hFFFFFF, 8'hFF, 1'b0, 0, "R10 reset seq", 0);
    run_txn(1'b0, 8'h00, 24'h000200, 8'h00, 1'b0, 0, "R10 cleared", 0);
    run_txn(1'b1, 8'hE7, 24'h000800, 8'h00, 1'b1, 1, "R10 command", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule